// File: doc/BRIEF.md
# Banked Register File with Return Stack

This block is the internal data memory of a small 8-bit controller core. One 64-byte array holds two banks of eight working registers, a sixteen-byte return-address stack and general scratch RAM. The core reaches it four ways: by register number within the selected bank, indirectly through the first or second register of that bank used as a pointer, by a direct byte address, and through push and pop ports for subroutine calls and returns.

Register bytes of the bank that is not selected, and stack bytes that no nesting level holds, are plain RAM. Switching banks changes which physical bytes the register ports and the two pointer registers resolve to, so the core has four pointers spread over the two banks. All reads are registered and return the data held before any write of the same cycle.

Top module: `banked_ram_stack`

## Requirements
- R1: While reset is low, and in the first cycle after it, the stack pointer is 0, `pop_valid` is 0, every read output is 0 and every RAM byte reads 0.
- R2: With `bank_sel` = 0, register number n (0..7) names RAM byte n. Every read port returns the byte addressed in one cycle on the next clock edge.
- R3: With `bank_sel` = 1, register number n names RAM byte 24+n. Bytes 24..31 can still be reached through indirect and direct access whichever bank is selected.
- R4: An indirect access uses as its address the byte held in register 0 (`sel` = 0) or register 1 (`sel` = 1) of the selected bank.
- R5: An indirect access uses only the low 6 bits of the pointer byte, and a direct access uses only the low 6 bits of its 8-bit address, so both wrap inside the 64 bytes.
- R6: A push writes `push_pc[7:0]` to byte 8+2*SP and `{push_stat, push_pc[11:8]}` (status in bits 7:4) to byte 9+2*SP, then advances SP by one.
- R7: A pop first steps SP back by one, then returns byte 8+2*SP' on `pop_pc[7:0]`, bits 3:0 of byte 9+2*SP' on `pop_pc[11:8]` and bits 7:4 of that byte on `pop_stat`, with `pop_valid` high in the following cycle only.
- R8: SP is 3 bits and wraps silently: a push at 7 gives 0, and a pop at 0 gives 7 and reads bytes 22 and 23.
- R9: Stack bytes 8..23 are ordinary RAM for direct and indirect access.
- R10: A read and a write to the same byte in the same cycle return the old contents. The new value is visible from the next read.
- R11: When several writes hit one byte in a cycle, the push wins over the register write, which wins over the indirect write, which wins over the direct write.
- R12: When push and pop are both asserted in a cycle, only the pop acts. SP steps back by one and the push data is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bank_sel | input | 1 | Selected register bank |
| reg_rd_idx | input | 3 | Register number to read |
| reg_rd_data | output | 8 | Registered register read data |
| reg_we | input | 1 | Register write enable |
| reg_wr_idx | input | 3 | Register number to write |
| reg_wr_data | input | 8 | Register write data |
| ind_rd_sel | input | 1 | Pointer register for indirect read |
| ind_rd_data | output | 8 | Registered indirect read data |
| ind_we | input | 1 | Indirect write enable |
| ind_wr_sel | input | 1 | Pointer register for indirect write |
| ind_wr_data | input | 8 | Indirect write data |
| dir_rd_addr | input | 8 | Direct read address |
| dir_rd_data | output | 8 | Registered direct read data |
| dir_we | input | 1 | Direct write enable |
| dir_wr_addr | input | 8 | Direct write address |
| dir_wr_data | input | 8 | Direct write data |
| push | input | 1 | Push return address |
| push_pc | input | 12 | Return address to push |
| push_stat | input | 4 | Status bits to push |
| pop | input | 1 | Pop return address |
| pop_pc | output | 12 | Popped return address |
| pop_stat | output | 4 | Popped status bits |
| pop_valid | output | 1 | Pop data valid |
| sp | output | 3 | Stack pointer |

## Verification
The bench checks bank mapping by reading one byte through both banks. A design with the wrong bank offset returns zero instead of the stored value. It walks pointers through a stack byte and through an out-of-range pointer 0xFF, which catches a design that ignores the bank for pointers or fails to truncate the address. It pushes and pops across both SP wrap points and issues push and pop together, so an off-by-one pointer or a pop that reads before decrementing shows up as wrong return data. Same-cycle collisions check read-before-write and the write priority, where a reversed priority leaves the losing writer's byte in RAM.

// File: rtl/banked_ram_stack.sv
module banked_ram_stack #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int EXT_AW     = 8,
  parameter int IDX_W      = 3,
  parameter int SP_W       = 3,
  parameter int PC_W       = 12,
  parameter int ST_W       = 4,
  parameter int STACK_BASE = 8,
  parameter int BANK1_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic [IDX_W-1:0]  reg_rd_idx,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_wr_idx,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              ind_rd_sel,
  output logic [DATA_W-1:0] ind_rd_data,
  input  logic              ind_we,
  input  logic              ind_wr_sel,
  input  logic [DATA_W-1:0] ind_wr_data,
  input  logic [EXT_AW-1:0] dir_rd_addr,
  output logic [DATA_W-1:0] dir_rd_data,
  input  logic              dir_we,
  input  logic [EXT_AW-1:0] dir_wr_addr,
  input  logic [DATA_W-1:0] dir_wr_data,
  input  logic              push,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [ST_W-1:0]   push_stat,
  input  logic              pop,
  output logic [PC_W-1:0]   pop_pc,
  output logic [ST_W-1:0]   pop_stat,
  output logic              pop_valid,
  output logic [SP_W-1:0]   sp
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = PC_W - DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] bank_base, reg_rd_loc, reg_wr_loc;
  logic [ADDR_W-1:0] ptr_rd_loc, ptr_wr_loc, ind_rd_loc, ind_wr_loc;
  logic [ADDR_W-1:0] dir_rd_loc, dir_wr_loc;
  logic [ADDR_W-1:0] push_lo, push_hi, pop_lo, pop_hi;
  logic [SP_W-1:0]   sp_dec;
  logic [DATA_W-1:0] push_hi_byte, pop_hi_byte;
  logic              do_push;

  assign bank_base  = bank_sel ? ADDR_W'(BANK1_BASE) : '0;
  assign reg_rd_loc = bank_base + ADDR_W'(reg_rd_idx);
  assign reg_wr_loc = bank_base + ADDR_W'(reg_wr_idx);
  assign ptr_rd_loc = bank_base + ADDR_W'(ind_rd_sel);
  assign ptr_wr_loc = bank_base + ADDR_W'(ind_wr_sel);
  assign ind_rd_loc = mem[ptr_rd_loc][ADDR_W-1:0];
  assign ind_wr_loc = mem[ptr_wr_loc][ADDR_W-1:0];
  assign dir_rd_loc = dir_rd_addr[ADDR_W-1:0];
  assign dir_wr_loc = dir_wr_addr[ADDR_W-1:0];

  assign sp_dec  = sp - SP_W'(1);
  assign push_lo = ADDR_W'(STACK_BASE) + ADDR_W'({sp, 1'b0});
  assign push_hi = push_lo + ADDR_W'(1);
  assign pop_lo  = ADDR_W'(STACK_BASE) + ADDR_W'({sp_dec, 1'b0});
  assign pop_hi  = pop_lo + ADDR_W'(1);
  assign do_push = push & ~pop;

  assign push_hi_byte = {push_stat, push_pc[PC_W-1:DATA_W]};
  assign pop_hi_byte  = mem[pop_hi];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      sp          <= '0;
      reg_rd_data <= '0;
      ind_rd_data <= '0;
      dir_rd_data <= '0;
      pop_pc      <= '0;
      pop_stat    <= '0;
      pop_valid   <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_push && ADDR_W'(i) == push_lo)
          mem[i] <= push_pc[DATA_W-1:0];
        else if (do_push && ADDR_W'(i) == push_hi)
          mem[i] <= push_hi_byte;
        else if (reg_we && ADDR_W'(i) == reg_wr_loc)
          mem[i] <= reg_wr_data;
        else if (ind_we && ADDR_W'(i) == ind_wr_loc)
          mem[i] <= ind_wr_data;
        else if (dir_we && ADDR_W'(i) == dir_wr_loc)
          mem[i] <= dir_wr_data;
      end
      reg_rd_data <= mem[reg_rd_loc];
      ind_rd_data <= mem[ind_rd_loc];
      dir_rd_data <= mem[dir_rd_loc];
      pop_valid   <= pop;
      if (pop) begin
        sp       <= sp_dec;
        pop_pc   <= {pop_hi_byte[HI_W-1:0], mem[pop_lo]};
        pop_stat <= pop_hi_byte[DATA_W-1:DATA_W-ST_W];
      end else if (do_push) begin
        sp <= sp + SP_W'(1);
      end
    end
  end

  p_reg_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> mem[$past(reg_wr_loc)] == $past(reg_wr_data));

  p_push_low_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> mem[ADDR_W'(STACK_BASE) + ADDR_W'({$past(sp), 1'b0})] == $past(push_pc[DATA_W-1:0]));

  p_push_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> sp == SP_W'($past(sp) + SP_W'(1)));

  p_pop_sp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp == SP_W'($past(sp) - SP_W'(1)));

  p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> pop_valid);

  p_pop_valid_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> !pop_valid);

  p_roundtrip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) ##1 (pop && !push) |=>
      ({pop_stat, pop_pc} == $past({push_stat, push_pc}, 2)));

  p_read_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dir_rd_data == $past(mem[dir_rd_addr[ADDR_W-1:0]]));

endmodule

// File: tb/banked_ram_stack_tb.sv
`timescale 1ns/1ps
module banked_ram_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_sel = 1'b0;
  logic [2:0]  reg_rd_idx = '0, reg_wr_idx = '0;
  logic [7:0]  reg_rd_data, reg_wr_data = '0;
  logic        reg_we = 1'b0;
  logic        ind_rd_sel = 1'b0, ind_wr_sel = 1'b0, ind_we = 1'b0;
  logic [7:0]  ind_rd_data, ind_wr_data = '0;
  logic [7:0]  dir_rd_addr = '0, dir_wr_addr = '0, dir_wr_data = '0, dir_rd_data;
  logic        dir_we = 1'b0;
  logic        push = 1'b0, pop = 1'b0, pop_valid;
  logic [11:0] push_pc = '0, pop_pc;
  logic [3:0]  push_stat = '0, pop_stat;
  logic [2:0]  sp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  banked_ram_stack dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .reg_we(reg_we), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .ind_rd_sel(ind_rd_sel), .ind_rd_data(ind_rd_data),
    .ind_we(ind_we), .ind_wr_sel(ind_wr_sel), .ind_wr_data(ind_wr_data),
    .dir_rd_addr(dir_rd_addr), .dir_rd_data(dir_rd_data),
    .dir_we(dir_we), .dir_wr_addr(dir_wr_addr), .dir_wr_data(dir_wr_data),
    .push(push), .push_pc(push_pc), .push_stat(push_stat),
    .pop(pop), .pop_pc(pop_pc), .pop_stat(pop_stat),
    .pop_valid(pop_valid), .sp(sp)
  );

  localparam int OP_DW = 0, OP_DR = 1, OP_RW = 2, OP_RR = 3,
                 OP_BK = 4, OP_IW = 5, OP_IR = 6;
  localparam int NV = 23;
  localparam logic [27:0] VEC [NV] = '{
    {4'd0, 8'h05, 8'h11, 8'h00},
    {4'd3, 8'h05, 8'h00, 8'h11},  // R2
    {4'd0, 8'h1C, 8'h22, 8'h00},
    {4'd3, 8'h04, 8'h00, 8'h00},  // R2
    {4'd4, 8'h01, 8'h00, 8'h00},
    {4'd3, 8'h04, 8'h00, 8'h22},  // R3
    {4'd2, 8'h00, 8'h30, 8'h00},
    {4'd5, 8'h00, 8'h77, 8'h00},
    {4'd1, 8'h30, 8'h00, 8'h77},  // R4
    {4'd4, 8'h00, 8'h00, 8'h00},
    {4'd2, 8'h00, 8'h10, 8'h00},
    {4'd5, 8'h00, 8'h55, 8'h00},
    {4'd1, 8'h10, 8'h00, 8'h55},  // R9
    {4'd2, 8'h01, 8'hFF, 8'h00},
    {4'd5, 8'h01, 8'h66, 8'h00},
    {4'd1, 8'h3F, 8'h00, 8'h66},  // R5
    {4'd1, 8'h7F, 8'h00, 8'h66},  // R5
    {4'd6, 8'h00, 8'h00, 8'h55},  // R4
    {4'd4, 8'h01, 8'h00, 8'h00},
    {4'd6, 8'h00, 8'h00, 8'h77},  // R4
    {4'd1, 8'h18, 8'h00, 8'h30},  // R3
    {4'd6, 8'h01, 8'h00, 8'h10},  // R4
    {4'd4, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_we = 0; ind_we = 0; dir_we = 0; push = 0; pop = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic dread(input logic [7:0] a, input string tag, input logic [7:0] exp);
    dir_rd_addr = a;
    step();
    chk(tag, dir_rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sp", sp, 0);
    chk("R1 pop_valid", pop_valid, 0);
    chk("R1 reg_rd_data", reg_rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dir_rd_data", dir_rd_data, 0);
    chk("R1 pop_pc", pop_pc, 0);

    for (int v = 0; v < NV; v++) begin
      int op;
      logic [7:0] a, b, e;
      op = int'(VEC[v][27:24]);
      a = VEC[v][23:16]; b = VEC[v][15:8]; e = VEC[v][7:0];
      case (op)
        OP_DW: begin dir_we = 1; dir_wr_addr = a; dir_wr_data = b; step(); end
        OP_DR: begin dir_rd_addr = a; step(); chk("R3 R5 R9 direct read", dir_rd_data, e); end
        OP_RW: begin reg_we = 1; reg_wr_idx = a[2:0]; reg_wr_data = b; step(); end
        OP_RR: begin reg_rd_idx = a[2:0]; step(); chk("R2 R3 register read", reg_rd_data, e); end
        OP_BK: begin bank_sel = a[0]; step(); end
        OP_IW: begin ind_we = 1; ind_wr_sel = a[0]; ind_wr_data = b; step(); end
        OP_IR: begin ind_rd_sel = a[0]; step(); chk("R4 indirect read", ind_rd_data, e); end
        default: ;
      endcase
    end

    push = 1; push_pc = 12'hABC; push_stat = 4'h5; step();
    chk("R6 sp after push", sp, 1);
    dread(8'd8, "R6 low byte", 8'hBC);
    dread(8'd9, "R6 high byte", 8'h5A);

    pop = 1; step();
    chk("R7 pop_valid", pop_valid, 1);
    chk("R7 pop_pc", pop_pc, 12'hABC);
    chk("R7 pop_stat", pop_stat, 4'h5);
    chk("R7 sp after pop", sp, 0);
    step();
    chk("R7 pop_valid drops", pop_valid, 0);

    pop = 1; step();
    chk("R8 sp wraps down", sp, 7);
    chk("R8 pop reads bytes 22/23", pop_pc, 12'h000);
    push = 1; push_pc = 12'h123; push_stat = 4'hF; step();
    chk("R8 sp wraps up", sp, 0);
    dread(8'd22, "R8 byte 22", 8'h23);
    dread(8'd23, "R8 byte 23", 8'hF1);

    push = 1; push_pc = 12'h3C4; push_stat = 4'h2;
    dir_we = 1; dir_wr_addr = 8'd8; dir_wr_data = 8'hEE; step();
    dread(8'd8, "R11 push beats direct", 8'hC4);
    pop = 1; step();
    chk("R11 pop after collision", pop_pc, 12'h3C4);

    reg_we = 1; reg_wr_idx = 3'd3; reg_wr_data = 8'hA1;
    dir_we = 1; dir_wr_addr = 8'd3; dir_wr_data = 8'hB2; step();
    dread(8'd3, "R11 register beats direct", 8'hA1);
    ind_we = 1; ind_wr_sel = 0; ind_wr_data = 8'h44;
    dir_we = 1; dir_wr_addr = 8'd16; dir_wr_data = 8'h99; step();
    dread(8'd16, "R11 indirect beats direct", 8'h44);
    reg_we = 1; reg_wr_idx = 3'd4; reg_wr_data = 8'h0C;
    ind_we = 1; ind_wr_sel = 1; ind_wr_data = 8'h0D; step();
    reg_wr_idx = 3'd1; reg_wr_data = 8'h04; reg_we = 1; step();
    reg_we = 1; reg_wr_idx = 3'd4; reg_wr_data = 8'h5E;
    ind_we = 1; ind_wr_sel = 1; ind_wr_data = 8'h6F; step();
    dread(8'd4, "R11 register beats indirect", 8'h5E);

    dir_we = 1; dir_wr_addr = 8'd40; dir_wr_data = 8'h5A; dir_rd_addr = 8'd40; step();
    chk("R10 same-cycle read returns old", dir_rd_data, 8'h00);
    dread(8'd40, "R10 new value next read", 8'h5A);

    push = 1; push_pc = 12'h111; push_stat = 4'h1; step();
    push = 1; pop = 1; push_pc = 12'h222; push_stat = 4'h2; step();
    chk("R12 sp after push+pop", sp, 0);
    chk("R12 pop data", pop_pc, 12'h111);
    chk("R12 pop status", pop_stat, 4'h1);
    dread(8'd8, "R12 push data not stored", 8'h11);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule